// File: doc/BRIEF.md
# Low-Register Integer ALU for the Compact Instruction Set

This unit is the execute stage for the 16-bit compact encodings that operate only on registers r0 to r7. It handles three instruction shapes. The first is a shift by an immediate amount. The second is a three-operand add or subtract whose second operand is either a low register or a 3-bit immediate. The third is a move, compare, add or subtract against an 8-bit immediate. A decode stage ahead of it has already identified the format. That stage passes in the low 13 bits of the instruction word, the operand values read from the 8-entry low register file, and the current N, Z, C and V flags.

The arithmetic is purely combinational. The write-back value, destination index, write enable, illegal indication and new flag set are captured on the rising clock edge in any cycle where `in_valid` is high. A register file and a flag register downstream consume these outputs in the cycle after the instruction was presented. Flags are packed as {N, Z, C, V} in bits 3 down to 0 on both `flags_in` and `flags_out`.

Top module: `lowreg_alu`

## Requirements
- R1: `in_fmt` selects the format: 00 shift, 01 three-operand add/subtract, 10 8-bit immediate, 11 reserved. In the shift format, bits 12:11 hold the shift type (00 left, 01 logical right, 10 arithmetic right), bits 10:6 hold the amount, bits 5:3 name the source (its value arrives on `op_a`) and bits 2:0 name the destination.
- R2: A left shift by 0 returns `op_a` unchanged and keeps C. A left shift by n (1 to 31) sets C to bit 32-n of the source.
- R3: A logical right shift with amount field 0 acts as a shift by 32: the result is 0 and C is source bit 31. For n from 1 to 31, C is source bit n-1.
- R4: An arithmetic right shift with amount field 0 acts as a shift by 32: every result bit and C equal source bit 31. For n from 1 to 31, the shift is sign-filling and C is source bit n-1.
- R5: After any legal operation that updates flags, N equals result bit 31 and Z is set exactly when the result is zero. A shift leaves V unchanged.
- R6: In the three-operand format, the destination is in bits 2:0 and the first operand is `op_a`. Bit 10 set selects the zero-extended 3-bit immediate in bits 8:6 as the second operand; bit 10 clear selects `op_b`. Bit 9 set means subtract.
- R7: For an add, C is the unsigned carry out of bit 31. V is set when both operands have the same sign and the result's sign differs from it.
- R8: For a subtract or compare, C is set when the subtrahend is unsigned less than or equal to the minuend. V is set when the operand signs differ and the result's sign differs from the minuend's.
- R9: In the 8-bit immediate format, bits 12:11 pick MOV (00), CMP (01), ADD (10) or SUB (11). Bits 10:8 name the register: it is the destination, and its value is `op_a`. Bits 7:0 give the immediate. CMP writes nothing. MOV keeps C and V.
- R10: Shift type 11 and format 11 are illegal. For these, `illegal` is raised, `wb_en` stays low and the flags are passed through unchanged.
- R11: In a cycle where `in_valid` is low, the next edge clears `wb_en` and `illegal`, and `wb_data`, `wb_idx` and `flags_out` hold their values.
- R12: A synchronous reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_fmt | input | 2 | Pre-decoded format code |
| in_insn | input | 13 | Low 13 bits of the instruction word |
| op_a | input | 32 | First source value (shift/three-operand source, or the immediate-format register) |
| op_b | input | 32 | Second register operand for the three-operand format |
| flags_in | input | 4 | Current {N,Z,C,V} |
| wb_en | output | 1 | Register write enable |
| wb_idx | output | 3 | Destination register index |
| wb_data | output | 32 | Result value |
| flags_out | output | 4 | Updated {N,Z,C,V} |
| illegal | output | 1 | Unsupported operation was presented |

## Verification
Every result is exposed one edge after it is presented. A wrong field decode, a carry taken from the wrong bit, or a zero-amount shift decoded as a no-op therefore shows up in the very next cycle as a mismatch on `wb_data`, `wb_idx` or `flags_out`. The corner cases that matter most are the amount-zero shifts, operands that sit on the sign and carry boundaries, and equal operands in a subtract. A faulty hold path is different: a write enable that stays set, or flags that drift while `in_valid` is low, only becomes visible during idle cycles. For that reason, idle cycles are interleaved with the active ones.

// File: rtl/lowalu_pkg.sv
package lowalu_pkg;

    localparam int WORD_W = 32;
    localparam int IDX_W  = 3;
    localparam int INSN_W = 13;

    typedef enum logic [1:0] {
        FMT_SHIFT   = 2'b00,
        FMT_ADDSUB3 = 2'b01,
        FMT_IMM8    = 2'b10,
        FMT_RSVD    = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_BAD = 2'b11
    } shop_e;

    typedef enum logic [1:0] {
        IM_MOV = 2'b00,
        IM_CMP = 2'b01,
        IM_ADD = 2'b10,
        IM_SUB = 2'b11
    } imop_e;

    typedef enum logic [1:0] {
        SEL_SHIFT,
        SEL_ARITH,
        SEL_MOVE
    } rsel_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    function automatic flags_t nz_update(input flags_t base, input logic msb, input logic is_zero);
        flags_t f;
        f   = base;
        f.n = msb;
        f.z = is_zero;
        return f;
    endfunction

endpackage

// File: rtl/lowalu_decode.sv
module lowalu_decode
    import lowalu_pkg::*;
#(
    parameter int DATA_W = WORD_W,
    localparam int AMT_W = $clog2(DATA_W)
) (
    input  logic [1:0]        fmt,
    input  logic [INSN_W-1:0] insn,
    input  logic [DATA_W-1:0] opb,
    output shop_e             sh_op,
    output logic [AMT_W-1:0]  sh_amt,
    output logic [IDX_W-1:0]  dst,
    output logic [DATA_W-1:0] arith_b,
    output logic              do_sub,
    output rsel_e             sel,
    output logic              wr,
    output logic              ill
);
    always_comb begin
        sh_op   = shop_e'(insn[12:11]);
        sh_amt  = insn[10:6];
        dst     = insn[2:0];
        arith_b = opb;
        do_sub  = 1'b0;
        sel     = SEL_SHIFT;
        wr      = 1'b1;
        ill     = 1'b0;
        unique case (fmt_e'(fmt))
            FMT_SHIFT: begin
                ill = (shop_e'(insn[12:11]) == SH_BAD);
            end
            FMT_ADDSUB3: begin
                sel     = SEL_ARITH;
                do_sub  = insn[9];
                arith_b = insn[10] ? DATA_W'(insn[8:6]) : opb;
            end
            FMT_IMM8: begin
                dst     = insn[10:8];
                arith_b = DATA_W'(insn[7:0]);
                unique case (imop_e'(insn[12:11]))
                    IM_MOV: sel = SEL_MOVE;
                    IM_CMP: begin sel = SEL_ARITH; do_sub = 1'b1; wr = 1'b0; end
                    IM_ADD: sel = SEL_ARITH;
                    IM_SUB: begin sel = SEL_ARITH; do_sub = 1'b1; end
                endcase
            end
            default: begin
                ill = 1'b1;
                wr  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/lowalu_shift.sv
module lowalu_shift
    import lowalu_pkg::*;
#(
    parameter int DATA_W = WORD_W,
    localparam int AMT_W = $clog2(DATA_W),
    localparam int EXT_W = DATA_W + 1
) (
    input  logic [DATA_W-1:0] a,
    input  shop_e             op,
    input  logic [AMT_W-1:0]  amt,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              cout
);
    logic [AMT_W:0]   ramt;
    logic [EXT_W-1:0] ext;

    // An amount field of zero on a right shift stands for a full-width shift.
    assign ramt = (amt == '0) ? (AMT_W+1)'(DATA_W) : {1'b0, amt};

    always_comb begin
        ext  = '0;
        res  = a;
        cout = cin;
        unique case (op)
            SH_LSL: begin
                ext  = {1'b0, a} << amt;
                res  = ext[DATA_W-1:0];
                cout = (amt == '0) ? cin : ext[DATA_W];
            end
            SH_LSR: begin
                ext  = {a, 1'b0} >> ramt;
                res  = ext[DATA_W:1];
                cout = ext[0];
            end
            SH_ASR: begin
                ext  = $signed({a, 1'b0}) >>> ramt;
                res  = ext[DATA_W:1];
                cout = ext[0];
            end
            default: begin
                res  = a;
                cout = cin;
            end
        endcase
    end
endmodule

// File: rtl/lowalu_arith.sv
module lowalu_arith
    import lowalu_pkg::*;
#(
    parameter int DATA_W = WORD_W,
    localparam int MSB = DATA_W - 1
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    output logic [DATA_W-1:0] res,
    output logic              cout,
    output logic              ovf
);
    logic [DATA_W:0]   sum;
    logic [DATA_W-1:0] ovf_vec;

    always_comb begin
        if (sub) begin
            sum     = {1'b0, a} - {1'b0, b};
            res     = sum[DATA_W-1:0];
            cout    = (b <= a);
            ovf_vec = (a ^ res) & (~b ^ res);
        end else begin
            sum     = {1'b0, a} + {1'b0, b};
            res     = sum[DATA_W-1:0];
            cout    = sum[DATA_W];
            ovf_vec = (a ^ res) & (b ^ res);
        end
        ovf = ovf_vec[MSB];
    end
endmodule

// File: rtl/lowreg_alu.sv
module lowreg_alu
    import lowalu_pkg::*;
#(
    parameter int DATA_W = WORD_W,
    localparam int AMT_W = $clog2(DATA_W),
    localparam int MSB   = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        in_fmt,
    input  logic [INSN_W-1:0] in_insn,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [3:0]        flags_in,
    output logic              wb_en,
    output logic [IDX_W-1:0]  wb_idx,
    output logic [DATA_W-1:0] wb_data,
    output logic [3:0]        flags_out,
    output logic              illegal
);
    flags_t            fin, fnext;
    shop_e             sh_op;
    logic [AMT_W-1:0]  sh_amt;
    logic [IDX_W-1:0]  dst;
    logic [DATA_W-1:0] arith_b, sh_res, ar_res, res;
    logic              do_sub, wr, ill, sh_c, ar_c, ar_v;
    rsel_e             sel;

    assign fin = flags_t'(flags_in);

    lowalu_decode #(.DATA_W(DATA_W)) dec_i (
        .fmt(in_fmt), .insn(in_insn), .opb(op_b),
        .sh_op(sh_op), .sh_amt(sh_amt), .dst(dst), .arith_b(arith_b),
        .do_sub(do_sub), .sel(sel), .wr(wr), .ill(ill)
    );

    lowalu_shift #(.DATA_W(DATA_W)) shf_i (
        .a(op_a), .op(sh_op), .amt(sh_amt), .cin(fin.c),
        .res(sh_res), .cout(sh_c)
    );

    lowalu_arith #(.DATA_W(DATA_W)) ari_i (
        .a(op_a), .b(arith_b), .sub(do_sub),
        .res(ar_res), .cout(ar_c), .ovf(ar_v)
    );

    always_comb begin
        unique case (sel)
            SEL_ARITH: res = ar_res;
            SEL_MOVE:  res = arith_b;
            default:   res = sh_res;
        endcase
        fnext = nz_update(fin, res[MSB], res == '0);
        if (sel == SEL_SHIFT) begin
            fnext.c = sh_c;
        end else if (sel == SEL_ARITH) begin
            fnext.c = ar_c;
            fnext.v = ar_v;
        end
        if (ill) begin
            fnext = fin;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_en     <= 1'b0;
            wb_idx    <= '0;
            wb_data   <= '0;
            flags_out <= '0;
            illegal   <= 1'b0;
        end else if (in_valid) begin
            wb_en     <= wr && !ill;
            wb_idx    <= dst;
            wb_data   <= res;
            flags_out <= fnext;
            illegal   <= ill;
        end else begin
            wb_en     <= 1'b0;
            illegal   <= 1'b0;
        end
    end

    // R10
    illegal_blocks_write_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !wb_en);

    // R10
    illegal_flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ill) |=> (flags_out == $past(flags_in)));

    // R11
    idle_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!wb_en && !illegal));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(wb_data) && $stable(flags_out) && $stable(wb_idx)));

    // R5
    shift_keeps_v_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_fmt == FMT_SHIFT && in_insn[12:11] != SH_BAD)
        |=> (flags_out[0] == $past(flags_in[0])));

    // R5
    nz_match_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !ill) |=> (flags_out[3] == wb_data[MSB] && flags_out[2] == (wb_data == '0)));

    // R9
    cmp_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_fmt == FMT_IMM8 && in_insn[12:11] == IM_CMP)
        |=> (!wb_en && wb_idx == $past(in_insn[10:8])));

    // R9
    mov_keeps_cv_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_fmt == FMT_IMM8 && in_insn[12:11] == IM_MOV)
        |=> (flags_out[1:0] == $past(flags_in[1:0]) && wb_en));
endmodule

// File: tb/lowreg_alu_tb.sv
`timescale 1ns/1ps
module lowreg_alu_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  in_fmt;
    logic [12:0] in_insn;
    logic [31:0] op_a, op_b;
    logic [3:0]  flags_in;
    logic        wb_en, illegal;
    logic [2:0]  wb_idx;
    logic [31:0] wb_data;
    logic [3:0]  flags_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    lowreg_alu dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_fmt(in_fmt), .in_insn(in_insn),
        .op_a(op_a), .op_b(op_b), .flags_in(flags_in),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data), .flags_out(flags_out),
        .illegal(illegal)
    );

    function automatic logic [12:0] enc_sh(input logic [1:0] op, input logic [4:0] amt,
                                            input logic [2:0] rs, input logic [2:0] rd);
        return {op, amt, rs, rd};
    endfunction

    function automatic logic [12:0] enc_as(input logic imm, input logic sub, input logic [2:0] f,
                                            input logic [2:0] rs, input logic [2:0] rd);
        return {2'b11, imm, sub, f, rs, rd};
    endfunction

    function automatic logic [12:0] enc_im(input logic [1:0] op, input logic [2:0] rd,
                                            input logic [7:0] imm);
        return {op, rd, imm};
    endfunction

    // Reference model built from the requirements.
    function automatic void model(input logic [1:0] f, input logic [12:0] w,
                                  input logic [31:0] a, input logic [31:0] b, input logic [3:0] fi,
                                  output logic [31:0] d, output logic [2:0] idx, output logic we,
                                  output logic ill, output logic [3:0] fo);
        logic [31:0] bb;
        logic [32:0] s;
        logic        c, v, sub;
        int          k;
        d = a; idx = w[2:0]; we = 1'b1; ill = 1'b0; c = fi[1]; v = fi[0];
        sub = 1'b0; bb = b;
        if (f == 2'b00) begin
            k = int'(w[10:6]);
            case (w[12:11])
                2'b00: begin
                    if (k == 0) d = a;
                    else begin d = a << k; c = a[32-k]; end
                end
                2'b01: begin
                    if (k == 0) k = 32;
                    d = (k == 32) ? 32'd0 : (a >> k);
                    c = a[k-1];
                end
                2'b10: begin
                    if (k == 0) k = 32;
                    d = (k == 32) ? {32{a[31]}} : 32'($signed(a) >>> k);
                    c = a[k-1];
                end
                default: ill = 1'b1;
            endcase
        end else if (f == 2'b11) begin
            ill = 1'b1;
        end else begin
            if (f == 2'b01) begin
                bb  = w[10] ? {29'd0, w[8:6]} : b;
                sub = w[9];
            end else begin
                idx = w[10:8];
                bb  = {24'd0, w[7:0]};
                sub = w[11];
                if (w[12:11] == 2'b01) we = 1'b0;
            end
            if (f == 2'b10 && w[12:11] == 2'b00) begin
                d = bb;
            end else if (sub) begin
                d = a - bb;
                c = (a >= bb);
                v = (a[31] != bb[31]) && (d[31] != a[31]);
            end else begin
                s = {1'b0, a} + {1'b0, bb};
                d = s[31:0];
                c = s[32];
                v = (a[31] == bb[31]) && (d[31] != a[31]);
            end
        end
        if (ill) begin
            we = 1'b0;
            fo = fi;
        end else begin
            fo = {d[31], d == 32'd0, c, v};
        end
    endfunction

    function automatic string tag_of(input logic [1:0] f, input logic [12:0] w);
        if (f == 2'b11) return "R10";
        if (f == 2'b00) begin
            case (w[12:11])
                2'b00:   return "R2";
                2'b01:   return "R3";
                2'b10:   return "R4";
                default: return "R10";
            endcase
        end
        if (f == 2'b01) return w[9] ? "R6 R8" : "R6 R7";
        if (w[12:11] == 2'b10) return "R9 R7";
        if (w[12:11] == 2'b00) return "R9";
        return "R9 R8";
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Present one instruction at a falling edge, capture at the rising edge, compare at the next falling edge.
    task automatic apply(input logic [1:0] f, input logic [12:0] w, input logic [31:0] a,
                         input logic [31:0] b, input logic [3:0] fi, input string tag);
        logic [31:0] d;
        logic [2:0]  idx;
        logic        we, ill;
        logic [3:0]  fo;
        in_valid = 1'b1; in_fmt = f; in_insn = w; op_a = a; op_b = b; flags_in = fi;
        model(f, w, a, b, fi, d, idx, we, ill, fo);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check(tag, "wb_en", 32'(wb_en), 32'(we));
        check(tag, "illegal", 32'(illegal), 32'(ill));
        check(tag, "flags", 32'(flags_out), 32'(fo));
        if (!ill) begin
            check(tag, "wb_idx", 32'(wb_idx), 32'(idx));
            check(tag, "wb_data", wb_data, d);
        end
    endtask

    task automatic idle_cycle();
        logic [31:0] d0;
        logic [3:0]  f0;
        logic [2:0]  i0;
        d0 = wb_data; f0 = flags_out; i0 = wb_idx;
        in_valid = 1'b0;
        in_fmt = 2'($urandom); in_insn = 13'($urandom);
        op_a = $urandom; op_b = $urandom; flags_in = 4'($urandom);
        @(posedge clk);
        @(negedge clk);
        check("R11", "idle wb_en", 32'(wb_en), 32'd0);
        check("R11", "idle illegal", 32'(illegal), 32'd0);
        check("R11", "idle data", wb_data, d0);
        check("R11", "idle flags", 32'(flags_out), 32'(f0));
        check("R11", "idle idx", 32'(wb_idx), 32'(i0));
    endtask

    function automatic logic [31:0] pick_val();
        case ($urandom % 8)
            0: return 32'h0000_0000;
            1: return 32'hFFFF_FFFF;
            2: return 32'h8000_0000;
            3: return 32'h7FFF_FFFF;
            4: return 32'(($urandom % 16));
            default: return $urandom;
        endcase
    endfunction

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; in_valid = 1'b0; in_fmt = 2'b00; in_insn = '0;
        op_a = '0; op_b = '0; flags_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12: outputs cleared by reset
        check("R12", "reset wb_en", 32'(wb_en), 32'd0);
        check("R12", "reset illegal", 32'(illegal), 32'd0);
        check("R12", "reset data", wb_data, 32'd0);
        check("R12", "reset flags", 32'(flags_out), 32'd0);
        check("R12", "reset idx", 32'(wb_idx), 32'd0);
        rst = 1'b0;

        // R1: field positions of the shift format
        apply(2'b00, enc_sh(2'b00, 5'd4, 3'd2, 3'd5), 32'h0000_0011, 32'h0, 4'b0000, "R1");
        check("R1", "dest index", 32'(wb_idx), 32'd5);
        check("R1", "shifted value", wb_data, 32'h0000_0110);
        // R2: zero amount keeps value and C
        apply(2'b00, enc_sh(2'b00, 5'd0, 3'd1, 3'd1), 32'h8000_0001, 32'h0, 4'b0010, "R2");
        apply(2'b00, enc_sh(2'b00, 5'd0, 3'd1, 3'd1), 32'h8000_0001, 32'h0, 4'b0001, "R2");
        // R2 R5: last bit out into C, zero result sets Z, V untouched
        apply(2'b00, enc_sh(2'b00, 5'd1, 3'd0, 3'd3), 32'h8000_0000, 32'h0, 4'b0001, "R2 R5");
        check("R5", "Z and V after shift to zero", 32'(flags_out), 32'b0111);
        apply(2'b00, enc_sh(2'b00, 5'd31, 3'd0, 3'd3), 32'h0000_0003, 32'h0, 4'b0000, "R2");
        // R3: logical right by 32 and by 1
        apply(2'b00, enc_sh(2'b01, 5'd0, 3'd4, 3'd6), 32'h8000_0000, 32'h0, 4'b0000, "R3");
        check("R3", "shift-32 result", wb_data, 32'h0);
        apply(2'b00, enc_sh(2'b01, 5'd1, 3'd4, 3'd6), 32'h0000_0001, 32'h0, 4'b0000, "R3");
        // R4: arithmetic right by 32 for both signs, and a nonzero amount
        apply(2'b00, enc_sh(2'b10, 5'd0, 3'd7, 3'd0), 32'h8000_0000, 32'h0, 4'b0000, "R4");
        check("R4", "sign fill", wb_data, 32'hFFFF_FFFF);
        apply(2'b00, enc_sh(2'b10, 5'd0, 3'd7, 3'd0), 32'h7FFF_FFFF, 32'h0, 4'b0010, "R4");
        apply(2'b00, enc_sh(2'b10, 5'd4, 3'd7, 3'd0), 32'hF000_0008, 32'h0, 4'b0000, "R4");
        // R6: immediate versus register operand
        apply(2'b01, enc_as(1'b1, 1'b0, 3'd7, 3'd1, 3'd2), 32'd5, 32'd100, 4'b0000, "R6");
        check("R6", "imm3 add", wb_data, 32'd12);
        apply(2'b01, enc_as(1'b0, 1'b1, 3'd3, 3'd1, 3'd2), 32'd5, 32'd100, 4'b0000, "R6 R8");
        // R7: signed overflow, and an unsigned carry to zero
        apply(2'b01, enc_as(1'b0, 1'b0, 3'd0, 3'd0, 3'd0), 32'h7FFF_FFFF, 32'd1, 4'b0000, "R7");
        check("R7", "overflow flags", 32'(flags_out), 32'b1001);
        apply(2'b01, enc_as(1'b1, 1'b0, 3'd1, 3'd0, 3'd0), 32'hFFFF_FFFF, 32'd0, 4'b0000, "R7");
        check("R7", "carry flags", 32'(flags_out), 32'b0110);
        // R8: equal operands, borrow, and overflow in subtraction
        apply(2'b01, enc_as(1'b0, 1'b1, 3'd0, 3'd0, 3'd1), 32'd5, 32'd5, 4'b0000, "R8");
        check("R8", "equal subtract flags", 32'(flags_out), 32'b0110);
        apply(2'b01, enc_as(1'b1, 1'b1, 3'd1, 3'd0, 3'd1), 32'd0, 32'd0, 4'b0000, "R8");
        apply(2'b01, enc_as(1'b0, 1'b1, 3'd0, 3'd0, 3'd1), 32'h8000_0000, 32'd1, 4'b0000, "R8");
        // R9: each immediate op
        apply(2'b10, enc_im(2'b00, 3'd6, 8'hFF), 32'h1234, 32'h0, 4'b0011, "R9");
        check("R9", "MOV keeps C V", 32'(flags_out), 32'b0011);
        apply(2'b10, enc_im(2'b01, 3'd3, 8'd9), 32'd9, 32'h0, 4'b0000, "R9");
        check("R9", "CMP no write", 32'(wb_en), 32'd0);
        apply(2'b10, enc_im(2'b10, 3'd2, 8'hFF), 32'hFFFF_FF01, 32'h0, 4'b0000, "R9 R7");
        apply(2'b10, enc_im(2'b11, 3'd2, 8'h10), 32'h0000_0008, 32'h0, 4'b0000, "R9 R8");
        // R10: illegal shift type and reserved format
        apply(2'b00, enc_sh(2'b11, 5'd3, 3'd1, 3'd1), 32'h55, 32'h0, 4'b1010, "R10");
        apply(2'b11, 13'h1ABC, 32'h55, 32'h66, 4'b0101, "R10");
        // R11: idle cycles hold state
        idle_cycle();
        idle_cycle();

        for (int i = 0; i < 1500; i++) begin
            logic [1:0]  f;
            logic [12:0] w;
            f = ($urandom % 16 == 0) ? 2'b11 : 2'($urandom % 3);
            w = 13'($urandom);
            apply(f, w, pick_val(), pick_val(), 4'($urandom), tag_of(f, w));
            if ($urandom % 5 == 0) idle_cycle();
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule